// File: doc/BRIEF.md
# CPU Clock Standby Controller

This block decides when the processor core clock is held off to save power and when it comes back. While the system is idle (on hook, with no host command pending) and automatic standby is enabled, the block counts a run of idle cycles. It then stops the CPU clock and moves to standby. The free-running clock that feeds the serial port, the timers and the interrupt logic is never touched: only the derived `cpu_clk_o` is gated.

Three asynchronous events bring the core back from standby:
- a rising edge on the host's DTR line;
- a rising edge on the ring-detect line;
- the falling edge of a start bit on the host's serial transmit input.

Each line passes through a two-flop synchronizer and an edge flop, so a wake takes effect three clock edges after the pin changes. The serial line runs at a bit rate far below the system clock, so the core is running again long before the first data bit is sampled.

A separate full power-down mode is entered on a one-cycle firmware request, or on a falling DTR edge when the DTR power-down option is enabled. Only a new DTR rising edge, or reset, leaves power-down. The clock enable passes through a latch that is transparent only while the clock is low, so the gated clock never produces a shortened pulse.

Top module: `cg_standby_ctrl`

## Requirements
- R1: Reset (active-low, asynchronous) forces the mode to RUN (code 0) at once, and the CPU clock runs afterwards. The mode is never code 3.
- R2: With `stby_en_i` and `idle_i` both high in RUN for IDLE_DLY consecutive clock edges, the mode becomes STANDBY (code 1) on the IDLE_DLY-th edge. The count restarts from zero after every return to RUN.
- R3: With `stby_en_i` low, no standby is entered however long `idle_i` stays high. A single cycle of `idle_i` low restarts the idle count.
- R4: In STANDBY, a falling edge on `txd_i` returns the mode to RUN on the third clock edge after the pin changes; on the second edge the mode is still STANDBY. A rising edge on `txd_i` has no effect.
- R5: In STANDBY, a rising edge on `dtr_i` or on `ring_i` returns the mode to RUN on the third clock edge after the pin changes. A falling `ring_i` edge has no effect.
- R6: `cpu_clk_o` is high only while `clk` is high. A high phase of `clk` gives a `cpu_clk_o` pulse exactly when the mode held in the low phase just before it was RUN, so no pulse appears in STANDBY or POWERDOWN.
- R7: A one-cycle `sw_pd_i` pulse in RUN or STANDBY sets POWERDOWN (code 2) on the next edge. A falling `dtr_i` edge does the same on the third edge after the pin change, but only when `dtr_pd_en_i` is high; otherwise it is ignored.
- R8: In POWERDOWN, edges on `ring_i` and `txd_i` are ignored. Only a `dtr_i` rising edge returns the mode to RUN, on the third edge after the pin change.
- R9: When a power-down request and a standby wake event reach the state logic in the same cycle, POWERDOWN wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock of the always-on domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | System idle: on hook and no host command pending (synchronous) |
| stby_en_i | input | 1 | Allows automatic standby when high |
| dtr_pd_en_i | input | 1 | Lets a falling DTR edge request power-down |
| sw_pd_i | input | 1 | Firmware power-down request pulse (synchronous) |
| dtr_i | input | 1 | Host DTR line, active high, asynchronous |
| ring_i | input | 1 | Ring-detect line, active high, asynchronous |
| txd_i | input | 1 | Host serial transmit line, idles high, asynchronous |
| cpu_clk_o | output | 1 | Gated clock for the CPU domain |
| mode_o | output | 2 | Current mode: 0 RUN, 1 STANDBY, 2 POWERDOWN |

## Verification
A standby wake event and a power-down request can reach the state logic in the same cycle. The bench provokes this by dropping `txd_i` while in standby and timing a `sw_pd_i` pulse to the edge on which the synchronized start-bit edge appears. It judges the result by requiring POWERDOWN, not RUN, on that edge and no clock pulses afterwards. A second overlap, an idle count completing while a firmware request arrives, resolves the same way through the shared next-mode function.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_STBY = 2'd1,
    MODE_PDN  = 2'd2
  } cg_mode_e;

  // Next-mode decision; power-down requests outrank every wake source.
  function automatic cg_mode_e cg_next_mode(input cg_mode_e cur,
                                            input logic idle_done,
                                            input logic pd_req,
                                            input logic std_wake,
                                            input logic dtr_wake);
    cg_mode_e nxt;
    case (cur)
      MODE_RUN:  nxt = pd_req ? MODE_PDN : (idle_done ? MODE_STBY : MODE_RUN);
      MODE_STBY: nxt = pd_req ? MODE_PDN : (std_wake ? MODE_RUN : MODE_STBY);
      MODE_PDN:  nxt = dtr_wake ? MODE_RUN : MODE_PDN;
      default:   nxt = MODE_RUN;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/cg_edge_sync.sv
`timescale 1ns/1ps
module cg_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= RST_VAL;
    else        last_q <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~last_q;
  assign fall_o  = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/cg_idle_timer.sv
`timescale 1ns/1ps
module cg_idle_timer #(
  parameter int IDLE_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic done_o
);
  localparam int CW = (IDLE_DLY < 2) ? 1 : $clog2(IDLE_DLY);
  localparam logic [CW-1:0] LAST = CW'(IDLE_DLY - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = arm_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!arm_i)  cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cg_clk_gate.sv
`timescale 1ns/1ps
module cg_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic en_lat_o,
  output logic gclk_o
);
  // Transparent while clk is low: the enable settles before the high phase.
  always_latch begin
    if (!rst_n)    en_lat_o = 1'b1;
    else if (!clk) en_lat_o = en_i;
  end

  assign gclk_o = clk & en_lat_o;
endmodule

// File: rtl/cg_standby_ctrl.sv
`timescale 1ns/1ps
module cg_standby_ctrl
  import cg_pkg::*;
#(
  parameter int IDLE_DLY    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle_i,
  input  logic       stby_en_i,
  input  logic       dtr_pd_en_i,
  input  logic       sw_pd_i,
  input  logic       dtr_i,
  input  logic       ring_i,
  input  logic       txd_i,
  output logic       cpu_clk_o,
  output logic [1:0] mode_o
);
  cg_mode_e state_q, state_d;

  logic dtr_lvl, dtr_rise, dtr_fall;
  logic ring_lvl, ring_rise, ring_fall;
  logic txd_lvl, txd_rise, txd_fall;
  logic idle_arm, idle_done;
  logic std_wake, dtr_wake, pd_req;
  logic run_en, en_lat;

  cg_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dtr_sync (
    .clk(clk), .rst_n(rst_n), .async_i(dtr_i),
    .level_o(dtr_lvl), .rise_o(dtr_rise), .fall_o(dtr_fall));

  cg_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ring_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ring_i),
    .level_o(ring_lvl), .rise_o(ring_rise), .fall_o(ring_fall));

  // Serial line idles high: reset to 1 so release is not seen as a start bit.
  cg_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_txd_sync (
    .clk(clk), .rst_n(rst_n), .async_i(txd_i),
    .level_o(txd_lvl), .rise_o(txd_rise), .fall_o(txd_fall));

  assign idle_arm = (state_q == MODE_RUN) && idle_i && stby_en_i;

  cg_idle_timer #(.IDLE_DLY(IDLE_DLY)) u_idle (
    .clk(clk), .rst_n(rst_n), .arm_i(idle_arm), .done_o(idle_done));

  // Named wake and request events, shared with the bound checker.
  assign std_wake = dtr_rise | ring_rise | txd_fall;
  assign dtr_wake = dtr_rise;
  assign pd_req   = sw_pd_i | (dtr_pd_en_i & dtr_fall);

  assign state_d = cg_next_mode(state_q, idle_done, pd_req, std_wake, dtr_wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_RUN;
    else        state_q <= state_d;
  end

  assign run_en = (state_q == MODE_RUN);
  assign mode_o = state_q;

  cg_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en_i(run_en),
    .en_lat_o(en_lat), .gclk_o(cpu_clk_o));

  // Levels and the unused edges are part of the synchronizer interface only.
  logic unused_ok;
  assign unused_ok = &{1'b0, dtr_lvl, ring_lvl, ring_fall, txd_lvl, txd_rise, en_lat};
endmodule

// File: rtl/cg_standby_sva.sv
`timescale 1ns/1ps
module cg_standby_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       idle_i,
  input logic       stby_en_i,
  input logic [1:0] mode,
  input logic       cpu_clk,
  input logic       std_wake,
  input logic       dtr_wake,
  input logic       pd_req
);
  a_r1_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  a_r2_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && $past(mode) == 2'd0) |-> $past(stby_en_i && idle_i));

  a_r4_wake_returns_run: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && std_wake && !pd_req) |=> mode == 2'd0);

  a_r6_gclk_low_before_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk);

  a_r7_pd_request_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd2 && pd_req) |=> mode == 2'd2);

  a_r8_pdn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !dtr_wake) |=> mode == 2'd2);

  a_r9_pd_beats_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && std_wake && pd_req) |=> mode == 2'd2);
endmodule

bind cg_standby_ctrl cg_standby_sva u_sva (
  .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .stby_en_i(stby_en_i),
  .mode(mode_o), .cpu_clk(cpu_clk_o), .std_wake(std_wake),
  .dtr_wake(dtr_wake), .pd_req(pd_req));

// File: tb/sim_cg_standby_ctrl.sv
`timescale 1ns/1ps
module sim_cg_standby_ctrl;
  localparam int D = 4;
  localparam logic [1:0] RUN = 2'd0, STBY = 2'd1, PDN = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idle = 1'b0, en = 1'b0, pden = 1'b0, swpd = 1'b0;
  logic dtr = 1'b0, ring = 1'b0, txd = 1'b1;
  logic gclk;
  logic [1:0] mode;

  int cyc = 0;
  int checks = 0, fails = 0;

  typedef struct { int c; logic [1:0] m; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cg_standby_ctrl #(.IDLE_DLY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .stby_en_i(en),
    .dtr_pd_en_i(pden), .sw_pd_i(swpd), .dtr_i(dtr), .ring_i(ring),
    .txd_i(txd), .cpu_clk_o(gclk), .mode_o(mode));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expect_at(input int c, input logic [1:0] m, input string tag);
    exp_t e;
    e.c = c; e.m = m; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected modes as their cycle comes up; R6 low-phase check.
  logic [1:0] mode_hist = 2'd0;
  bit hist_ok = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      while (q.size() > 0 && q[0].c <= cyc) begin
        if (q[0].c == cyc) check(mode == q[0].m, q[0].tag, mode, q[0].m);
        else               check(1'b0, {q[0].tag, " (missed)"}, q[0].c, cyc);
        void'(q.pop_front());
      end
    end
    mode_hist = mode;
    hist_ok   = rst_n;
    #1;
    if (rst_n) check(gclk == 1'b0, "R6 gated clock low in low phase", gclk, 0);
  end

  // R6: pulse in a high phase only if the mode seen in the low phase was RUN.
  always @(posedge clk) begin
    #1;
    if (rst_n && hist_ok)
      check(gclk == (mode_hist == RUN), "R6 gated clock pulse", gclk, (mode_hist == RUN));
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 5000);
      finish_up();
    end
  end

  initial begin
    int c;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(mode == RUN, "R1 mode after reset", mode, RUN);

    // R3: standby disabled
    en = 1'b0; idle = 1'b1;
    expect_at(cyc + 8, RUN, "R3 no standby while disabled");
    tick(9);
    // R3: idle break restarts count, then R2 entry
    en = 1'b1; tick(2); idle = 1'b0; tick(1); idle = 1'b1;
    c = cyc;
    expect_at(c + D - 1, RUN, "R3 count restarted after idle gap");
    expect_at(c + D, STBY, "R2 standby entry after IDLE_DLY edges");
    tick(D + 1);

    // R4: start-bit wake, latency, then R2 re-entry with fresh count
    c = cyc; txd = 1'b0;
    expect_at(c + 2, STBY, "R4 still standby during synchronizer");
    expect_at(c + 3, RUN, "R4 txd start bit wakes");
    expect_at(c + 2 + D, RUN, "R2 count restarts after wake");
    expect_at(c + 3 + D, STBY, "R2 re-entry after wake");
    tick(D + 4);
    c = cyc; txd = 1'b1;
    expect_at(c + 5, STBY, "R4 txd rising edge ignored");
    tick(6);

    // R5: DTR wake
    c = cyc; dtr = 1'b1;
    expect_at(c + 2, STBY, "R5 dtr synchronizer latency");
    expect_at(c + 3, RUN, "R5 dtr rising wakes");
    expect_at(c + 3 + D, STBY, "R2 re-entry after dtr wake");
    tick(D + 4);
    c = cyc; dtr = 1'b0;
    expect_at(c + 5, STBY, "R7 dtr fall ignored when option off");
    tick(6);
    // R5: RING wake
    c = cyc; ring = 1'b1;
    expect_at(c + 3, RUN, "R5 ring rising wakes");
    expect_at(c + 3 + D, STBY, "R2 re-entry after ring wake");
    tick(D + 4);
    c = cyc; ring = 1'b0;
    expect_at(c + 5, STBY, "R5 ring falling edge ignored");
    tick(6);

    // Back to RUN without re-entry
    c = cyc; idle = 1'b0; txd = 1'b0;
    expect_at(c + 3, RUN, "R4 txd wake before power-down tests");
    tick(4); txd = 1'b1; tick(4);

    // R7: firmware power-down from RUN
    c = cyc; swpd = 1'b1;
    expect_at(c + 1, PDN, "R7 firmware request enters power-down");
    tick(1); swpd = 1'b0;
    // R8: ring and txd ignored in power-down
    c = cyc; ring = 1'b1; txd = 1'b0;
    expect_at(c + 5, PDN, "R8 ring and txd ignored in power-down");
    tick(6);
    c = cyc; ring = 1'b0; txd = 1'b1;
    expect_at(c + 5, PDN, "R8 ring and txd release ignored");
    tick(6);
    c = cyc; dtr = 1'b1;
    expect_at(c + 2, PDN, "R8 dtr synchronizer latency");
    expect_at(c + 3, RUN, "R8 dtr rising leaves power-down");
    tick(4);

    // R7: DTR-driven power-down
    pden = 1'b1;
    c = cyc; dtr = 1'b0;
    expect_at(c + 2, RUN, "R7 dtr fall latency");
    expect_at(c + 3, PDN, "R7 dtr fall enters power-down");
    tick(4);
    pden = 1'b0;
    c = cyc; dtr = 1'b1;
    expect_at(c + 3, RUN, "R8 dtr rising leaves power-down");
    tick(4);

    // R9: wake and power-down request meet at the same edge
    idle = 1'b1;
    c = cyc;
    expect_at(c + D, STBY, "R2 standby before collision test");
    tick(D + 1);
    c = cyc; txd = 1'b0;
    expect_at(c + 3, PDN, "R9 power-down beats start-bit wake");
    expect_at(c + 6, PDN, "R9 stays in power-down");
    tick(2); swpd = 1'b1; tick(1); swpd = 1'b0;
    tick(4);
    txd = 1'b1; idle = 1'b0; dtr = 1'b0; tick(4);
    c = cyc; dtr = 1'b1;
    expect_at(c + 3, RUN, "R8 dtr wake after collision");
    tick(4);

    // R1: asynchronous reset from standby
    idle = 1'b1;
    c = cyc;
    expect_at(c + D, STBY, "R2 standby before reset test");
    tick(D + 1);
    check(mode == STBY, "R2 in standby before reset", mode, STBY);
    idle = 1'b0;
    #1 rst_n = 1'b0;
    #1 check(mode == RUN, "R1 reset forces RUN at once", mode, RUN);
    tick(2);
    rst_n = 1'b1;
    tick(3);
    check(mode == RUN, "R1 RUN after reset release", mode, RUN);
    check(q.size() == 0, "R1 all expectations consumed", q.size(), 0);
    finish_up();
  end
endmodule